// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the device side of an asynchronous multiplexed-address DRAM interface. A fast core clock samples the four control strobes (row strobe, column strobe, write enable, output enable) and the shared address bus. The decoder works out what kind of memory cycle the controller is running from the order in which the strobes change, not from their levels alone. Row and column addresses are latched at the matching strobe falls. The decoder keeps the internal refresh row counter and decides when the data pins may be driven.

Each classified cycle appears as a 4-bit code together with a one-clock valid pulse. Access cycles are classified when their column strobe (or row strobe) rises, so a late write enable can still turn a read into a delayed write or a read-modify-write. Refresh cycles are classified when the row strobe rises. The one exception is self refresh, which is announced as soon as the row strobe has stayed low for a set number of clocks inside a column-before-row cycle. The strobe levels are active-low. All thresholds are counted in core clocks.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, cyc_valid, dq_oe and self_rfsh are 0, cyc_type is 0, and row_addr, col_addr and rfsh_row are all 0.
- R2: A row strobe fall while the column strobe is high latches addr into row_addr. If the row strobe then rises with no column strobe fall, the cycle is reported as code 6 (row-only refresh) and dq_oe stays 0 throughout.
- R3: A column strobe fall after the row strobe fall, with write enable high, latches addr[COL_W-1:0] into col_addr. dq_oe is 1 while output enable is low. When the column strobe rises, the cycle is reported as code 1 (read).
- R4: If write enable is low at the column strobe fall, the cycle is reported as code 2 (early write), and dq_oe stays 0 even while output enable is low.
- R5: If write enable falls while the column strobe is low after a read start, the cycle is reported as code 4 (read-modify-write) when output enable was seen low before that fall, and as code 3 (delayed write) otherwise. dq_oe goes to 0 at the write enable fall.
- R6: While the row strobe stays low, each further column strobe fall latches a new column and leaves row_addr unchanged. Each such access is reported as code 5 (page continuation) when its column strobe rises. Read data stays driven while the column strobe is high between accesses.
- R7: A column strobe fall while the row strobe is high and write enable is high, followed by a row strobe fall, is a column-before-row refresh. When the row strobe rises, it is reported as code 7, rfsh_row advances by one, and row_addr keeps its value whatever is on addr.
- R8: If the row strobe rises and falls again while the column strobe stays low after an access, read data stays driven throughout. When the row strobe rises the second time, the cycle is reported as code 8 (hidden refresh) and rfsh_row advances by one.
- R9: If the row strobe stays low for SELF_ENTRY_CYC clocks in a column-before-row cycle, code 9 (self refresh) is reported once, and self_rfsh stays 1 until the row strobe rises. No code 7 is reported for that cycle, rfsh_row does not advance, and dq_oe stays 0.
- R10: cyc_valid is high for exactly one clock per classified cycle, and cyc_type reads 0 (standby) whenever cyc_valid is low.
- R11: Once both row and column strobes are seen high, dq_oe is 0.
- R12: rfsh_row is RF_W bits wide and wraps modulo 2^RF_W: after 2048 refreshes at the default width, it returns to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed address bus |
| cyc_valid | output | 1 | One-clock pulse marking a classified cycle |
| cyc_type | output | 4 | Cycle code, valid with cyc_valid, 0 otherwise |
| row_addr | output | ROW_W | Latched row address |
| col_addr | output | COL_W | Latched column address |
| rfsh_row | output | RF_W | Internal refresh row counter |
| dq_oe | output | 1 | Data pin drive enable |
| self_rfsh | output | 1 | High while in self refresh |

## Verification
A wrong state in the decoder shows up as a wrong code, or a missing or doubled pulse, three clocks after the strobe edge that should close the cycle. A stale write-tracking flag flips read-modify-write and delayed write, and that is visible at the column rise that ends the access. A bad data-live flag shows on dq_oe in the hold windows (page gaps, hidden refresh), where the data must stay driven. A counter or timer fault shows on rfsh_row right after the refresh, or on self_rfsh about SELF_ENTRY_CYC clocks after the row fall.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [3:0] {
    CY_STANDBY    = 4'd0,
    CY_READ       = 4'd1,
    CY_EARLY_WR   = 4'd2,
    CY_DELAYED_WR = 4'd3,
    CY_RMW        = 4'd4,
    CY_PAGE       = 4'd5,
    CY_RAS_ONLY   = 4'd6,
    CY_CBR        = 4'd7,
    CY_HIDDEN     = 4'd8,
    CY_SELF       = 4'd9
  } cyc_code_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_ACC,
    ST_PGWAIT,
    ST_PAGE,
    ST_HOLD,
    ST_HIDDEN,
    ST_CBR_ARM,
    ST_CBR,
    ST_SELF
  } fsm_st_e;

endpackage

// File: rtl/dcd_strobe_sampler.sv
module dcd_strobe_sampler #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              ras_l,
  output logic              cas_l,
  output logic              we_l,
  output logic              oe_l,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ras_fall,
  output logic              ras_rise,
  output logic              cas_fall,
  output logic              cas_rise,
  output logic              we_fall
);

  localparam int W = ADDR_W + 4;
  localparam logic [W-1:0] RST_V = {4'hF, {ADDR_W{1'b0}}};

  logic [SYNC_STAGES-1:0][W-1:0] stg;
  logic [W-1:0]                  cur;
  logic [2:0]                    prv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= RST_V;
      prv <= 3'b111;
    end else begin
      stg[0] <= {ras_n, cas_n, we_n, oe_n, addr};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      prv <= cur[W-1 -: 3];
    end
  end

  assign cur      = stg[SYNC_STAGES-1];
  assign ras_l    = cur[W-1];
  assign cas_l    = cur[W-2];
  assign we_l     = cur[W-3];
  assign oe_l     = cur[W-4];
  assign addr_q   = cur[ADDR_W-1:0];

  assign ras_fall = prv[2] & ~ras_l;
  assign ras_rise = ~prv[2] & ras_l;
  assign cas_fall = prv[1] & ~cas_l;
  assign cas_rise = ~prv[1] & cas_l;
  assign we_fall  = prv[0] & ~we_l;

endmodule

// File: rtl/dcd_cycle_fsm.sv
module dcd_cycle_fsm
  import dcd_pkg::*;
#(
  parameter int SELF_ENTRY_CYC = 12500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_l,
  input  logic       cas_l,
  input  logic       we_l,
  input  logic       oe_l,
  input  logic       ras_fall,
  input  logic       ras_rise,
  input  logic       cas_fall,
  input  logic       cas_rise,
  input  logic       we_fall,
  output logic       row_ld,
  output logic       col_ld,
  output logic       rf_inc,
  output logic       cyc_valid,
  output logic [3:0] cyc_type,
  output logic       dq_oe,
  output logic       self_rfsh
);

  localparam int LC_W = $clog2(SELF_ENTRY_CYC + 1);
  localparam logic [LC_W-1:0] LC_LAST = LC_W'(SELF_ENTRY_CYC - 1);

  fsm_st_e   st_q, st_n;
  cyc_code_e kind_q, kind_n;
  cyc_code_e code;
  logic      oes_q, oes_n;
  logic      live_q, live_n;
  logic      valid_q;
  cyc_code_e type_q;
  logic      dq_q;
  logic      emit;
  logic [LC_W-1:0] lc_q, lc_n;

  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    oes_n  = oes_q;
    live_n = live_q;
    lc_n   = '0;
    emit   = 1'b0;
    code   = CY_STANDBY;
    row_ld = 1'b0;
    col_ld = 1'b0;
    rf_inc = 1'b0;

    case (st_q)
      ST_IDLE: begin
        if (ras_fall && cas_l) begin
          row_ld = 1'b1;
          st_n   = ST_ROW;
        end else if (ras_fall) begin
          st_n = ST_CBR;
        end else if (cas_fall && ras_l && we_l) begin
          st_n = ST_CBR_ARM;
        end
      end

      ST_ROW, ST_PGWAIT: begin
        if (ras_rise) begin
          if (st_q == ST_ROW) begin
            emit = 1'b1;
            code = CY_RAS_ONLY;
          end
          st_n = ST_IDLE;
        end else if (cas_fall) begin
          col_ld = 1'b1;
          live_n = we_l;
          kind_n = we_l ? CY_READ : CY_EARLY_WR;
          oes_n  = ~oe_l;
          st_n   = (st_q == ST_ROW) ? ST_ACC : ST_PAGE;
        end
      end

      ST_ACC, ST_PAGE: begin
        if (kind_q == CY_READ) begin
          if (we_fall) begin
            kind_n = oes_q ? CY_RMW : CY_DELAYED_WR;
            live_n = 1'b0;
          end else if (!oe_l) begin
            oes_n = 1'b1;
          end
        end
        code = (st_q == ST_PAGE) ? CY_PAGE : kind_n;
        if (ras_rise && cas_rise) begin
          emit = 1'b1;
          st_n = ST_IDLE;
        end else if (cas_rise) begin
          emit = 1'b1;
          st_n = ST_PGWAIT;
        end else if (ras_rise) begin
          emit = 1'b1;
          st_n = ST_HOLD;
        end
      end

      ST_HOLD: begin
        if (cas_rise) st_n = ST_IDLE;
        else if (ras_fall) st_n = ST_HIDDEN;
      end

      ST_HIDDEN: begin
        if (ras_rise) begin
          emit   = 1'b1;
          code   = CY_HIDDEN;
          rf_inc = 1'b1;
          st_n   = cas_l ? ST_IDLE : ST_HOLD;
        end
      end

      ST_CBR_ARM: begin
        if (ras_fall) st_n = ST_CBR;
        else if (cas_rise) st_n = ST_IDLE;
      end

      ST_CBR: begin
        lc_n = lc_q + 1'b1;
        if (ras_rise) begin
          emit   = 1'b1;
          code   = CY_CBR;
          rf_inc = 1'b1;
          st_n   = cas_l ? ST_IDLE : ST_CBR_ARM;
        end else if (lc_q == LC_LAST) begin
          emit = 1'b1;
          code = CY_SELF;
          st_n = ST_SELF;
        end
      end

      ST_SELF: begin
        if (ras_rise) st_n = cas_l ? ST_IDLE : ST_CBR_ARM;
      end

      default: st_n = ST_IDLE;
    endcase

    if (ras_l && cas_l) live_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= CY_READ;
      oes_q   <= 1'b0;
      live_q  <= 1'b0;
      lc_q    <= '0;
      valid_q <= 1'b0;
      type_q  <= CY_STANDBY;
      dq_q    <= 1'b0;
    end else begin
      st_q    <= st_n;
      kind_q  <= kind_n;
      oes_q   <= oes_n;
      live_q  <= live_n;
      lc_q    <= lc_n;
      valid_q <= emit;
      type_q  <= emit ? code : CY_STANDBY;
      dq_q    <= live_n & ~oe_l;
    end
  end

  assign cyc_valid = valid_q;
  assign cyc_type  = type_q;
  assign dq_oe     = dq_q;
  assign self_rfsh = (st_q == ST_SELF);

endmodule

// File: rtl/dcd_addr_latch.sv
module dcd_addr_latch #(
  parameter int ROW_W = 11,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] addr_q,
  input  logic             row_ld,
  input  logic             col_ld,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_addr <= '0;
      col_addr <= '0;
    end else begin
      if (row_ld) row_addr <= addr_q;
      if (col_ld) col_addr <= addr_q[COL_W-1:0];
    end
  end

endmodule

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
  parameter int RF_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  output logic [RF_W-1:0] row
);

  logic [RF_W-1:0] row_n;

  always_comb row_n = row + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row <= '0;
    else if (inc) row <= row_n;
  end

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int ROW_W          = 11,
  parameter int COL_W          = 10,
  parameter int RF_W           = 11,
  parameter int SYNC_STAGES    = 2,
  parameter int SELF_ENTRY_CYC = 12500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  output logic             cyc_valid,
  output logic [3:0]       cyc_type,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic [RF_W-1:0]  rfsh_row,
  output logic             dq_oe,
  output logic             self_rfsh
);

  logic [1:0]       rs_q;
  logic             rst_core_n;
  logic             ras_l, cas_l, we_l, oe_l;
  logic             ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic [ROW_W-1:0] addr_q;
  logic             row_ld, col_ld, rf_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  dcd_strobe_sampler #(.ADDR_W(ROW_W), .SYNC_STAGES(SYNC_STAGES)) smp_i (
    .clk(clk), .rst_n(rst_core_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .ras_l(ras_l), .cas_l(cas_l), .we_l(we_l), .oe_l(oe_l), .addr_q(addr_q),
    .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall)
  );

  dcd_cycle_fsm #(.SELF_ENTRY_CYC(SELF_ENTRY_CYC)) fsm_i (
    .clk(clk), .rst_n(rst_core_n),
    .ras_l(ras_l), .cas_l(cas_l), .we_l(we_l), .oe_l(oe_l),
    .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall),
    .row_ld(row_ld), .col_ld(col_ld), .rf_inc(rf_inc),
    .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .dq_oe(dq_oe), .self_rfsh(self_rfsh)
  );

  dcd_addr_latch #(.ROW_W(ROW_W), .COL_W(COL_W)) lat_i (
    .clk(clk), .rst_n(rst_core_n), .addr_q(addr_q),
    .row_ld(row_ld), .col_ld(col_ld),
    .row_addr(row_addr), .col_addr(col_addr)
  );

  dcd_refresh_ctr #(.RF_W(RF_W)) rfc_i (
    .clk(clk), .rst_n(rst_core_n), .inc(rf_inc), .row(rfsh_row)
  );

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker
  import dcd_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int RF_W  = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_valid,
  input logic [3:0]       cyc_type,
  input logic [ROW_W-1:0] row_addr,
  input logic [RF_W-1:0]  rfsh_row,
  input logic             dq_oe,
  input logic             self_rfsh
);

  logic rf_event;
  assign rf_event = cyc_valid && (cyc_type == CY_CBR || cyc_type == CY_HIDDEN);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);

  assert_idle_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> cyc_type == CY_STANDBY);

  assert_early_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == CY_EARLY_WR) |-> !dq_oe);

  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_event |-> rfsh_row == RF_W'($past(rfsh_row) + 1'b1));

  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_event |-> $stable(rfsh_row));

  assert_row_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == CY_CBR) |-> $stable(row_addr));

  assert_self_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    self_rfsh |-> !dq_oe);

  assert_self_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(self_rfsh) |-> (cyc_valid && cyc_type == CY_SELF));

endmodule

bind dram_cycle_decoder dcd_checker #(.ROW_W(ROW_W), .RF_W(RF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
  .row_addr(row_addr), .rfsh_row(rfsh_row), .dq_oe(dq_oe), .self_rfsh(self_rfsh)
);

// File: tb/dram_cycle_decoder_tb_top.sv
module dram_cycle_decoder_tb_top;

  localparam int ROW_W  = 11;
  localparam int COL_W  = 10;
  localparam int RF_W   = 11;
  localparam int SELF_N = 200;

  logic             clk   = 1'b0;
  logic             rst_n = 1'b0;
  logic             ras_n = 1'b1;
  logic             cas_n = 1'b1;
  logic             we_n  = 1'b1;
  logic             oe_n  = 1'b1;
  logic [ROW_W-1:0] addr  = '0;
  logic             cyc_valid;
  logic [3:0]       cyc_type;
  logic [ROW_W-1:0] row_addr;
  logic [COL_W-1:0] col_addr;
  logic [RF_W-1:0]  rfsh_row;
  logic             dq_oe;
  logic             self_rfsh;

  int checks = 0;
  int fails  = 0;
  int ev_cnt = 0;
  int ev_type = 0;
  int cycles = 0;

  dram_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .RF_W(RF_W),
                       .SYNC_STAGES(2), .SELF_ENTRY_CYC(SELF_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .row_addr(row_addr), .col_addr(col_addr), .rfsh_row(rfsh_row),
    .dq_oe(dq_oe), .self_rfsh(self_rfsh)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (cyc_valid) begin
      ev_cnt  = ev_cnt + 1;
      ev_type = int'(cyc_type);
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    checks = checks + 1;
    if (got != exp) begin
      fails = fails + 1;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_kind(input bit early, input bit late, input bit oe_first);
    if (early)    return 2;
    if (late)     return oe_first ? 4 : 3;
    return 1;
  endfunction

  task automatic expect_ev(input string req, input int base, input int code);
    chk({req, " pulse count"}, ev_cnt - base, 1);
    chk({req, " code"}, ev_type, code);
  endtask

  task automatic access(input int row, input int col, input bit early,
                        input bit late, input bit oe_first, input string req);
    int base;
    addr = ROW_W'(row); ras_n = 1'b0; tick(4);
    chk({req, " row latch"}, int'(row_addr), row);
    addr = ROW_W'(col); we_n = !early; oe_n = !oe_first; cas_n = 1'b0; tick(4);
    chk({req, " col latch"}, int'(col_addr), col % (1 << COL_W));
    chk({req, " data drive"}, int'(dq_oe), int'(!early && oe_first));
    if (late && !early) begin
      we_n = 1'b0; tick(4);
      chk("R5 data off after late write", int'(dq_oe), 0);
    end
    base = ev_cnt; cas_n = 1'b1; tick(4);
    expect_ev(req, base, exp_kind(early, late && !early, oe_first));
    ras_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick(4);
    chk("R11 standby data off", int'(dq_oe), 0);
  endtask

  task automatic cbr_once(input int junk_addr, output int base);
    cas_n = 1'b0; tick(4);
    addr = ROW_W'(junk_addr); ras_n = 1'b0; tick(4);
    base = ev_cnt; ras_n = 1'b1; tick(4);
  endtask

  initial begin
    int unsigned seed_v;
    int base, rf0, row0, kind, r, c;
    bit early, late, oef;
    seed_v = $urandom(32'd51973);

    tick(5); rst_n = 1'b1; tick(6);
    chk("R1 cyc_valid", int'(cyc_valid), 0);
    chk("R1 cyc_type", int'(cyc_type), 0);
    chk("R1 dq_oe", int'(dq_oe), 0);
    chk("R1 self_rfsh", int'(self_rfsh), 0);
    chk("R1 rfsh_row", int'(rfsh_row), 0);
    chk("R1 row_addr", int'(row_addr), 0);
    chk("R1 col_addr", int'(col_addr), 0);

    // R2 row-only refresh
    addr = 11'h5A3; ras_n = 1'b0; tick(4);
    chk("R2 row latch", int'(row_addr), 'h5A3);
    chk("R2 data off", int'(dq_oe), 0);
    base = ev_cnt; ras_n = 1'b1; tick(4);
    expect_ev("R2", base, 6);
    chk("R2 data off after", int'(dq_oe), 0);

    // directed accesses
    access('h123, 'h3FF, 1'b0, 1'b0, 1'b1, "R3");
    access('h7FF, 'h2AA, 1'b0, 1'b0, 1'b0, "R3");
    access('h001, 'h155, 1'b1, 1'b0, 1'b1, "R4");
    access('h400, 'h0F0, 1'b0, 1'b1, 1'b1, "R5");
    access('h3C3, 'h00F, 1'b0, 1'b1, 1'b0, "R5");

    // R6 page continuation with extended data out
    addr = 11'h2B4; ras_n = 1'b0; tick(4);
    addr = 11'h011; oe_n = 1'b0; cas_n = 1'b0; tick(4);
    base = ev_cnt; cas_n = 1'b1; tick(4);
    expect_ev("R6 first", base, 1);
    chk("R6 data held in gap", int'(dq_oe), 1);
    addr = 11'h322; cas_n = 1'b0; tick(4);
    chk("R6 new col", int'(col_addr), 'h322);
    chk("R6 row kept", int'(row_addr), 'h2B4);
    base = ev_cnt; cas_n = 1'b1; tick(4);
    expect_ev("R6 page read", base, 5);
    addr = 11'h033; we_n = 1'b0; cas_n = 1'b0; tick(4);
    chk("R6 page write col", int'(col_addr), 'h033);
    chk("R6 page write data off", int'(dq_oe), 0);
    base = ev_cnt; cas_n = 1'b1; tick(4);
    expect_ev("R6 page write", base, 5);
    ras_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick(4);
    chk("R11 after page", int'(dq_oe), 0);

    // R7 CBR refresh ignores address
    rf0 = int'(rfsh_row); row0 = int'(row_addr);
    cbr_once('h6E6, base);
    expect_ev("R7", base, 7);
    chk("R7 counter step", int'(rfsh_row), (rf0 + 1) % 2048);
    chk("R7 row unchanged", int'(row_addr), row0);
    cas_n = 1'b1; tick(4);

    // R8 hidden refresh
    addr = 11'h111; ras_n = 1'b0; tick(4);
    addr = 11'h099; oe_n = 1'b0; cas_n = 1'b0; tick(4);
    base = ev_cnt; ras_n = 1'b1; tick(4);
    expect_ev("R8 lead read", base, 1);
    chk("R8 data held after row rise", int'(dq_oe), 1);
    rf0 = int'(rfsh_row);
    ras_n = 1'b0; tick(4);
    chk("R8 data held in hidden", int'(dq_oe), 1);
    base = ev_cnt; ras_n = 1'b1; tick(4);
    expect_ev("R8", base, 8);
    chk("R8 counter step", int'(rfsh_row), (rf0 + 1) % 2048);
    cas_n = 1'b1; oe_n = 1'b1; tick(4);
    chk("R11 after hidden", int'(dq_oe), 0);

    // R9 short CBR stays CBR, long enters self refresh
    rf0 = int'(rfsh_row);
    cas_n = 1'b0; tick(4); ras_n = 1'b0; tick(SELF_N / 2);
    chk("R9 no early self", int'(self_rfsh), 0);
    base = ev_cnt; ras_n = 1'b1; tick(4);
    expect_ev("R9 short is CBR", base, 7);
    chk("R9 short counted", int'(rfsh_row), (rf0 + 1) % 2048);
    rf0 = int'(rfsh_row);
    base = ev_cnt; ras_n = 1'b0; tick(SELF_N + 20);
    chk("R9 self active", int'(self_rfsh), 1);
    expect_ev("R9 self", base, 9);
    chk("R9 data off", int'(dq_oe), 0);
    ras_n = 1'b1; tick(4);
    chk("R9 self exit", int'(self_rfsh), 0);
    chk("R9 no CBR on exit", ev_cnt - base, 1);
    chk("R9 counter kept", int'(rfsh_row), rf0);
    cas_n = 1'b1; tick(4);

    // R12 wrap after full set of refreshes
    rf0 = int'(rfsh_row);
    base = ev_cnt;
    cas_n = 1'b0; tick(4);
    for (int i = 0; i < 2048; i++) begin
      ras_n = 1'b0; tick(4); ras_n = 1'b1; tick(4);
    end
    cas_n = 1'b1; tick(4);
    chk("R12 wrap", int'(rfsh_row), rf0);
    chk("R10 one pulse per refresh", ev_cnt - base, 2048);

    // random mixed accesses
    for (int i = 0; i < 40; i++) begin
      r = int'($urandom_range(2047, 0));
      c = int'($urandom_range(2047, 0));
      kind = int'($urandom_range(3, 0));
      oef = 1'($urandom_range(1, 0));
      early = (kind == 1);
      late  = (kind >= 2);
      if (kind == 3) oef = 1'b1;
      if (kind == 2) oef = 1'b0;
      access(r, c, early, late, oef, early ? "R4" : (late ? "R5" : "R3"));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule